// File: doc/BRIEF.md
# Three-Bank Selectable Clock Divider

This block turns one fast source clock into three banks of divided clocks. Bank A has five outputs, bank B has four, and bank C has two. Every output in a bank carries the same waveform. Each bank has its own two-way ratio select. A global range select puts a divide-by-2 stage in front of all three banks. Every ratio is even, so every output has a 50% duty cycle.

The source is either an oscillator clock or an external reference clock, chosen by a bypass input. A single active-high line serves as both reset and output enable. While it is high, every divider stage is cleared and every bank output floats. When it goes low, all outputs rise together on the first source edge.

Ratio and range changes are held back until the next common alignment point. That point is one source edge in every 24, where every bank is at the start of its period. A selectable tap brings one of the eleven outputs out as a feedback signal for an external phase loop.

Top module: `tri_bank_clkdiv`

## Requirements
- R1: Bank A divides the source by 4 when `sel_a` is 0 and by 6 when `sel_a` is 1 (with `range_hi` = 0).
- R2: Bank B divides the source by 4 when `sel_b` is 0 and by 2 when `sel_b` is 1 (with `range_hi` = 0).
- R3: Bank C divides the source by 2 when `sel_c` is 0 and by 4 when `sel_c` is 1 (with `range_hi` = 0).
- R4: With `range_hi` = 1, every bank ratio is doubled: A gives 8 or 12, B gives 8 or 4, and C gives 4 or 8.
- R5: Every output is high for exactly half of its period, counted in source edges.
- R6: After `rst_oe` falls, all eleven outputs go high on the first rising source edge. They stay in phase, so every output in a bank is identical and all banks rise together at the start of each period.
- R7: While `rst_oe` is 1, every bank output is high-impedance, so a weak pull-up on the line reads 1. The divider state is cleared and `fb_tap` is 0.
- R8: With `osc_bypass` = 1, the dividers count rising edges of `ref_clk`. With `osc_bypass` = 0, they count rising edges of `osc_clk`.
- R9: `fb_tap` carries one output, chosen by `tap_sel`:
  - values 0 to 4 select A output 0 to 4;
  - values 5 to 8 select B output 0 to 3;
  - values 9 and 10 select C output 0 and 1;
  - values 11 to 15 give a constant 0.
- R10: Source edges after reset are numbered from 0. A change on `sel_a`, `sel_b`, `sel_c` or `range_hi` is taken only on edges whose number is a multiple of 24. Until then, every bank keeps its current ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock, the normal divider source |
| ref_clk | input | 1 | External reference clock, used as the source when bypassed |
| osc_bypass | input | 1 | 1: divide `ref_clk`; 0: divide `osc_clk` |
| rst_oe | input | 1 | Active-high reset that also floats all bank outputs |
| range_hi | input | 1 | 1: add a divide-by-2 stage in front of all banks |
| sel_a | input | 1 | Bank A ratio select |
| sel_b | input | 1 | Bank B ratio select |
| sel_c | input | 1 | Bank C ratio select |
| tap_sel | input | 4 | Index of the output routed to `fb_tap` |
| bank_a_out | output | 5 | Bank A clocks, tri-stated in reset |
| bank_b_out | output | 4 | Bank B clocks, tri-stated in reset |
| bank_c_out | output | 2 | Bank C clocks, tri-stated in reset |
| fb_tap | output | 1 | Selected feedback clock |

## Verification
The bench sweeps all sixteen select combinations from reset. It compares every output, edge by edge, against the period and high time it computes on its own. A divider with a mismatched count limit, or an odd high time, shows up as a waveform that slips against that pattern. A design that started its banks out of step would fail the first-edge check.

The bench flips the ratio and range selects mid-frame and expects the old ratios to hold until edge 24. A block that applied the change at once would emit a runt pulse early.

Further runs confirm three more behaviours:
- the bank lines float while reset is held;
- in bypass, edges of the reference clock are counted instead of the oscillator;
- each tap index lands on the right bank, and indices above 10 give a steady zero.

// File: rtl/tbcd_pkg.sv
package tbcd_pkg;

    // Ratio and range selection applied to the three banks.
    typedef struct packed {
        logic range_hi;
        logic sel_a;
        logic sel_b;
        logic sel_c;
    } tbcd_cfg_t;

endpackage

// File: rtl/tbcd_frame_ctrl.sv
// Counts source edges in a frame of FRAME_LEN. The frame length is a common
// multiple of every ratio, so all banks restart together at frame start.
// New selects are accepted only on that edge.
module tbcd_frame_ctrl
    import tbcd_pkg::*;
#(
    parameter int FRAME_LEN = 24
) (
    input  logic      clk,
    input  logic      rst,
    input  tbcd_cfg_t cfg_live,
    output tbcd_cfg_t cfg_eff,
    output logic      frame_start
);

    localparam int POS_W = $clog2(FRAME_LEN);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        tbcd_cfg_t        cfg;
    } frame_st_t;

    frame_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        frame_start = (st_q.pos == '0);
        cfg_eff     = frame_start ? cfg_live : st_q.cfg;
        st_d.cfg    = cfg_eff;
        st_d.pos    = (st_q.pos == POS_W'(FRAME_LEN - 1)) ? '0 : st_q.pos + 1'b1;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.pos != '0) |=> $stable(st_q.cfg));

endmodule

// File: rtl/tbcd_bank_div.sv
// One bank divider: the ratio is RATIO_LO or RATIO_HI, doubled by the range
// stage. The output is registered and high for the first half of each period.
module tbcd_bank_div #(
    parameter int RATIO_LO = 4,
    parameter int RATIO_HI = 6,
    parameter int CNT_W    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_start,
    input  logic range_hi,
    input  logic sel,
    output logic clk_out
);

    typedef struct packed {
        logic [CNT_W-1:0] ph;
        logic             clk;
    } bank_st_t;

    bank_st_t         st_d, st_q;
    logic [CNT_W-1:0] ratio;
    logic [CNT_W-1:0] half;

    always_comb begin
        ratio      = (sel ? CNT_W'(RATIO_HI) : CNT_W'(RATIO_LO)) << range_hi;
        half       = ratio >> 1;
        st_d       = st_q;
        st_d.clk   = (st_q.ph < half);
        st_d.ph    = (st_q.ph == ratio - 1'b1) ? '0 : st_q.ph + 1'b1;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign clk_out = st_q.clk;

    // R5
    mid_half_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.ph != '0 && st_q.ph != half) |=> $stable(clk_out));

    // R6
    frame_align_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (st_q.ph == '0));

    // R6
    rise_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_out) |-> ($past(st_q.ph) == '0));

endmodule

// File: rtl/tbcd_tap_mux.sv
// Selects one of the bank outputs as the feedback tap; out-of-range gives 0.
module tbcd_tap_mux #(
    parameter int N_OUT = 11,
    parameter int SEL_W = 4
) (
    input  logic [N_OUT-1:0] all_out,
    input  logic [SEL_W-1:0] tap_sel,
    output logic             tap
);

    always_comb begin
        tap = 1'b0;
        for (int i = 0; i < N_OUT; i++) begin
            if (tap_sel == SEL_W'(i)) tap = all_out[i];
        end
    end

endmodule

// File: rtl/tri_bank_clkdiv.sv
module tri_bank_clkdiv
    import tbcd_pkg::*;
#(
    parameter int N_A       = 5,
    parameter int N_B       = 4,
    parameter int N_C       = 2,
    parameter int A_LO      = 4,
    parameter int A_HI      = 6,
    parameter int B_LO      = 4,
    parameter int B_HI      = 2,
    parameter int C_LO      = 2,
    parameter int C_HI      = 4,
    parameter int FRAME_LEN = 24
) (
    input  logic           osc_clk,
    input  logic           ref_clk,
    input  logic           osc_bypass,
    input  logic           rst_oe,
    input  logic           range_hi,
    input  logic           sel_a,
    input  logic           sel_b,
    input  logic           sel_c,
    input  logic [3:0]     tap_sel,
    output logic [N_A-1:0] bank_a_out,
    output logic [N_B-1:0] bank_b_out,
    output logic [N_C-1:0] bank_c_out,
    output logic           fb_tap
);

    localparam int N_ALL  = N_A + N_B + N_C;
    localparam int MAX_AB = (A_HI > A_LO) ? ((A_HI > B_LO) ? ((A_HI > B_HI) ? A_HI : B_HI)
                                                          : ((B_LO > B_HI) ? B_LO : B_HI))
                                          : ((A_LO > B_LO) ? ((A_LO > B_HI) ? A_LO : B_HI)
                                                          : ((B_LO > B_HI) ? B_LO : B_HI));
    localparam int MAX_C  = (C_HI > C_LO) ? C_HI : C_LO;
    localparam int MAX_R  = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
    localparam int CNT_W  = $clog2(2 * MAX_R + 1);

    logic       src_clk;
    tbcd_cfg_t  cfg_live;
    tbcd_cfg_t  cfg_eff;
    logic       frame_start;
    logic [2:0] bank_clk;
    logic [2:0] bank_sel;

    assign src_clk  = osc_bypass ? ref_clk : osc_clk;
    assign cfg_live = '{range_hi: range_hi, sel_a: sel_a, sel_b: sel_b, sel_c: sel_c};
    assign bank_sel = {cfg_eff.sel_c, cfg_eff.sel_b, cfg_eff.sel_a};

    tbcd_frame_ctrl #(.FRAME_LEN(FRAME_LEN)) u_frame (
        .clk        (src_clk),
        .rst        (rst_oe),
        .cfg_live   (cfg_live),
        .cfg_eff    (cfg_eff),
        .frame_start(frame_start)
    );

    for (genvar g = 0; g < 3; g++) begin : g_bank
        localparam int R_LO = (g == 0) ? A_LO : ((g == 1) ? B_LO : C_LO);
        localparam int R_HI = (g == 0) ? A_HI : ((g == 1) ? B_HI : C_HI);
        tbcd_bank_div #(.RATIO_LO(R_LO), .RATIO_HI(R_HI), .CNT_W(CNT_W)) u_div (
            .clk        (src_clk),
            .rst        (rst_oe),
            .frame_start(frame_start),
            .range_hi   (cfg_eff.range_hi),
            .sel        (bank_sel[g]),
            .clk_out    (bank_clk[g])
        );
    end

    logic [N_ALL-1:0] all_int;
    assign all_int = {{N_C{bank_clk[2]}}, {N_B{bank_clk[1]}}, {N_A{bank_clk[0]}}};

    assign bank_a_out = rst_oe ? 'z : all_int[N_A-1:0];
    assign bank_b_out = rst_oe ? 'z : all_int[N_A+N_B-1:N_A];
    assign bank_c_out = rst_oe ? 'z : all_int[N_ALL-1:N_A+N_B];

    tbcd_tap_mux #(.N_OUT(N_ALL), .SEL_W(4)) u_tap (
        .all_out(all_int),
        .tap_sel(tap_sel),
        .tap    (fb_tap)
    );

    // R6
    banks_rise_together_chk: assert property (@(posedge src_clk) disable iff (rst_oe)
        frame_start |=> (bank_clk == 3'b111));

endmodule

// File: tb/tri_bank_clkdiv_bench.sv
`timescale 1ns/1ps
module tri_bank_clkdiv_bench;

    logic       osc_clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       osc_bypass = 1'b0;
    logic       rst_oe = 1'b1;
    logic       range_hi = 1'b0;
    logic       sel_a = 1'b0;
    logic       sel_b = 1'b0;
    logic       sel_c = 1'b0;
    logic [3:0] tap_sel = 4'd0;
    wire  [4:0] a_w;
    wire  [3:0] b_w;
    wire  [1:0] c_w;
    wire        tap_w;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 osc_clk = ~osc_clk;
    always #3.5 ref_clk = ~ref_clk;

    for (genvar i = 0; i < 5; i++) begin : g_pa
        pullup (a_w[i]);
    end
    for (genvar i = 0; i < 4; i++) begin : g_pb
        pullup (b_w[i]);
    end
    for (genvar i = 0; i < 2; i++) begin : g_pc
        pullup (c_w[i]);
    end

    tri_bank_clkdiv u_tri_bank_clkdiv (
        .osc_clk(osc_clk), .ref_clk(ref_clk), .osc_bypass(osc_bypass),
        .rst_oe(rst_oe), .range_hi(range_hi), .sel_a(sel_a), .sel_b(sel_b),
        .sel_c(sel_c), .tap_sel(tap_sel), .bank_a_out(a_w), .bank_b_out(b_w),
        .bank_c_out(c_w), .fb_tap(tap_w)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected ratio from the requirement table (R1..R4).
    function automatic int ratio_of(int bank, bit s, bit rng);
        int base;
        if (bank == 0)      base = s ? 6 : 4;
        else if (bank == 1) base = s ? 2 : 4;
        else                base = s ? 4 : 2;
        return rng ? 2 * base : base;
    endfunction

    function automatic int bank_of(int o);
        return (o < 5) ? 0 : ((o < 9) ? 1 : 2);
    endfunction

    function automatic logic out_bit(int o);
        if (o < 5)      return a_w[o];
        else if (o < 9) return b_w[o-5];
        else            return c_w[o-9];
    endfunction

    function automatic bit exp_bit(int j, int n);
        return (j % n) < (n / 2);
    endfunction

    task automatic src_neg();
        if (osc_bypass) @(negedge ref_clk);
        else            @(negedge osc_clk);
    endtask

    // Hold reset, apply selects, check the floating state (R7), release.
    task automatic start(bit byp, bit rng, bit sa, bit sb, bit sc);
        src_neg();
        rst_oe = 1'b1;
        osc_bypass = byp; range_hi = rng; sel_a = sa; sel_b = sb; sel_c = sc;
        repeat (3) src_neg();
        chk(a_w === 5'h1f, "R7", "bank A floats in reset", int'(a_w), 31);
        chk(b_w === 4'hf,  "R7", "bank B floats in reset", int'(b_w), 15);
        chk(c_w === 2'h3,  "R7", "bank C floats in reset", int'(c_w), 3);
        rst_oe = 1'b0;
    endtask

    // R7: reset state at power-up
    task automatic t_reset_state();
        repeat (4) @(negedge osc_clk);
        chk(a_w === 5'h1f, "R7", "bank A z at start", int'(a_w), 31);
        chk(b_w === 4'hf,  "R7", "bank B z at start", int'(b_w), 15);
        chk(c_w === 2'h3,  "R7", "bank C z at start", int'(c_w), 3);
        chk(tap_w === 1'b0, "R7", "tap low in reset", int'(tap_w), 0);
    endtask

    // Per-output waveform check over nsamp source edges after release.
    task automatic run_wave(string req, bit rng, bit sa, bit sb, bit sc, int nsamp);
        int nbad[11];
        int fj[11];
        int fa[11];
        for (int o = 0; o < 11; o++) begin nbad[o] = 0; fj[o] = -1; fa[o] = 0; end
        for (int j = 0; j < nsamp; j++) begin
            src_neg();
            for (int o = 0; o < 11; o++) begin
                int  b = bank_of(o);
                int  n = ratio_of(b, (b == 0) ? sa : ((b == 1) ? sb : sc), rng);
                logic v = out_bit(o);
                if (v !== logic'(exp_bit(j, n))) begin
                    if (nbad[o] == 0) begin fj[o] = j; fa[o] = int'(v); end
                    nbad[o]++;
                end
            end
        end
        for (int o = 0; o < 11; o++) begin
            int b = bank_of(o);
            int n = ratio_of(b, (b == 0) ? sa : ((b == 1) ? sb : sc), rng);
            chk(nbad[o] == 0, req,
                $sformatf("out %0d rng=%0d sel=%0d%0d%0d edge %0d", o, rng, sa, sb, sc, fj[o]),
                fa[o], (fj[o] < 0) ? 0 : int'(exp_bit(fj[o], n)));
        end
    endtask

    // R1 R2 R3 R4 R5 R6: all sixteen combinations
    task automatic t_sweep();
        for (int c = 0; c < 16; c++) begin
            bit rng = c[3], sa = c[2], sb = c[1], sc = c[0];
            start(1'b0, rng, sa, sb, sc);
            run_wave("R1/R2/R3/R4/R5/R6", rng, sa, sb, sc, 48);
        end
    endtask

    // R8: reference clock drives the dividers in bypass
    task automatic t_bypass();
        start(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        run_wave("R8", 1'b0, 1'b1, 1'b0, 1'b1, 48);
        start(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        run_wave("R8", 1'b1, 1'b0, 1'b1, 1'b0, 48);
        start(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    // R9: feedback tap routing
    task automatic t_tap();
        for (int ts = 0; ts < 12; ts++) begin
            int nb = 0;
            int b  = (ts < 11) ? bank_of(ts) : 0;
            int n  = ratio_of(b, 1'b1, 1'b0);
            tap_sel = 4'(ts);
            start(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
            for (int j = 0; j < 24; j++) begin
                logic e;
                src_neg();
                e = (ts < 11) ? logic'(exp_bit(j, n)) : 1'b0;
                if (tap_w !== e) nb++;
            end
            chk(nb == 0, "R9", $sformatf("tap_sel %0d mismatching edges", ts), nb, 0);
        end
        tap_sel = 4'd0;
    endtask

    // R10: selects change mid-frame, take effect at edge 24
    task automatic t_midchange();
        int nb[3];
        start(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        nb[0] = 0; nb[1] = 0; nb[2] = 0;
        for (int j = 0; j < 60; j++) begin
            src_neg();
            for (int b = 0; b < 3; b++) begin
                int   n  = (j < 24) ? ratio_of(b, 1'b0, 1'b0) : ratio_of(b, (b == 0), 1'b1);
                int   jj = (j < 24) ? j : j - 24;
                logic v  = out_bit((b == 0) ? 0 : ((b == 1) ? 5 : 9));
                if (v !== logic'(exp_bit(jj, n))) nb[b]++;
            end
            if (j == 10) begin sel_a = 1'b1; range_hi = 1'b1; end
        end
        chk(nb[0] == 0, "R10", "bank A edges off after mid-frame change", nb[0], 0);
        chk(nb[1] == 0, "R10", "bank B edges off after mid-frame change", nb[1], 0);
        chk(nb[2] == 0, "R10", "bank C edges off after mid-frame change", nb[2], 0);
    endtask

    initial begin
        t_reset_state();
        t_sweep();
        t_bypass();
        t_tap();
        t_midchange();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule